// File: doc/BRIEF.md
# Real-Time Clock Alarm Match Comparator

This block watches the seconds, minutes and hours bytes of a real-time clock and compares them with three programmed alarm bytes. Once per completed clock update, signalled by a one-cycle strobe, it checks the three pairs. When every pair matches, it sets a sticky alarm flag. Any alarm byte whose two top bits are both ones is a wildcard, and that field always counts as matching.

The comparison is a raw byte equality. The block is therefore indifferent to the data mode (BCD or binary) and to the hour mode (12 or 24 hour) in use, as long as the time and alarm bytes are written in the same form. The flag stays set until a clear pulse arrives. That pulse stands for the read of a status register. An interrupt request is the flag gated by an alarm interrupt enable.

The block does not count time, convert number formats or decode any register access. A surrounding clock core supplies the bytes and the strobe, and a status register owner drives the clear.

Top module: `rtc_alarm_match`

## Requirements
- R1: Each alarm byte is compared only with its own time byte (secAlm with secNow, minAlm with minNow, hrAlm with hrNow) by exact 8-bit equality with no conversion, so bytes that differ only in bit 7 do not match.
- R2: An alarm byte with bits [7:6] equal to 2'b11 (values C0h to FFh) is a wildcard whose field always matches. A byte with bits [7:6] equal to 2'b10 (for example BFh) is compared normally.
- R3: When updDone is high on a clock edge and all three fields match, almFlag is high from the next cycle.
- R4: When updDone is high and any non-wildcard field differs, the flag is not set by that strobe.
- R5: Fields are evaluated only on cycles where updDone is high. Matching bytes without the strobe do not set the flag.
- R6: Once set, almFlag stays high until a cycle in which flagClr is high. After that edge it reads low, unless R7 applies.
- R7: When flagClr and a matching updDone occur in the same cycle, the flag is high afterwards.
- R8: irqReq is high exactly when almFlag and almIntEn are both high, with no register in between. Raising almIntEn while the flag is set raises irqReq in the same cycle.
- R9: While rstN is low, almFlag and irqReq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| updDone | input | 1 | One-cycle strobe at the end of each clock update |
| secNow | input | 8 | Current seconds byte |
| minNow | input | 8 | Current minutes byte |
| hrNow | input | 8 | Current hours byte |
| secAlm | input | 8 | Seconds alarm byte |
| minAlm | input | 8 | Minutes alarm byte |
| hrAlm | input | 8 | Hours alarm byte |
| almIntEn | input | 1 | Alarm interrupt enable |
| flagClr | input | 1 | Clear pulse for the alarm flag (status read) |
| almFlag | output | 1 | Sticky alarm flag |
| irqReq | output | 1 | Alarm interrupt request |

## Verification
The hardest case to reach from the ports is a clear pulse that lands in the same cycle as a matching update strobe. In that cycle the set must win over the clear. A second hard case is an enable that rises while the flag is already set. Directed phases place the clear and the matching strobe together after the flag has been set. The bench also toggles the enable on a held flag. A random phase then draws time and alarm bytes from a tiny value range, with frequent wildcards, so that matches, clears and strobes collide often. A behavioural model checks both outputs on every clock.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  parameter int BYTE_W     = 8;
  parameter int NUM_FIELDS = 3;
  parameter int WILD_W     = 2;

  typedef logic [BYTE_W-1:0] fieldByte_t;
  typedef fieldByte_t [NUM_FIELDS-1:0] fieldVec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
  } almStrobe_t;
endpackage

// File: rtl/rtc_alarm_datapath.sv
module rtc_alarm_datapath
  import rtc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  fieldVec_t  fieldsNow,
  input  fieldVec_t  fieldsAlm,
  input  almStrobe_t strb,
  output logic       allMatch,
  output logic       flagQ
);
  localparam int WILD_LSB = BYTE_W - WILD_W;

  logic [NUM_FIELDS-1:0] fieldHit;

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    logic isWild;
    logic isEqual;
    // top WILD_W bits all ones mark a don't-care alarm byte
    assign isWild  = &fieldsAlm[gi][BYTE_W-1:WILD_LSB];
    assign isEqual = (fieldsAlm[gi] == fieldsNow[gi]);
    assign fieldHit[gi] = isWild | isEqual;
  end

  assign allMatch = &fieldHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (strb.setFlag) begin
      flagQ <= 1'b1;
    end else if (strb.clrFlag) begin
      flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
(
  input  logic       updDone,
  input  logic       flagClr,
  input  logic       allMatch,
  input  logic       flagQ,
  input  logic       almIntEn,
  output almStrobe_t strb,
  output logic       irqReq
);
  always_comb begin
    strb.setFlag = updDone & allMatch;
    // a coincident set takes priority over the clear
    strb.clrFlag = flagClr & ~strb.setFlag;
    irqReq       = flagQ & almIntEn;
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       updDone,
  input  logic [7:0] secNow,
  input  logic [7:0] minNow,
  input  logic [7:0] hrNow,
  input  logic [7:0] secAlm,
  input  logic [7:0] minAlm,
  input  logic [7:0] hrAlm,
  input  logic       almIntEn,
  input  logic       flagClr,
  output logic       almFlag,
  output logic       irqReq
);
  fieldVec_t  fieldsNow;
  fieldVec_t  fieldsAlm;
  almStrobe_t strb;
  logic       allMatch;
  logic       flagQ;

  assign fieldsNow = {hrNow, minNow, secNow};
  assign fieldsAlm = {hrAlm, minAlm, secAlm};

  rtc_alarm_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .fieldsNow (fieldsNow),
    .fieldsAlm (fieldsAlm),
    .strb      (strb),
    .allMatch  (allMatch),
    .flagQ     (flagQ)
  );

  rtc_alarm_ctrl u_ctrl (
    .updDone  (updDone),
    .flagClr  (flagClr),
    .allMatch (allMatch),
    .flagQ    (flagQ),
    .almIntEn (almIntEn),
    .strb     (strb),
    .irqReq   (irqReq)
  );

  assign almFlag = flagQ;
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk (
  input logic       clk,
  input logic       rstN,
  input logic       updDone,
  input logic [7:0] secNow,
  input logic [7:0] minNow,
  input logic [7:0] hrNow,
  input logic [7:0] secAlm,
  input logic [7:0] minAlm,
  input logic [7:0] hrAlm,
  input logic       almIntEn,
  input logic       flagClr,
  input logic       almFlag,
  input logic       irqReq
);
  logic secOk, minOk, hrOk;
  assign secOk = (secAlm[7:6] == 2'b11) || (secAlm == secNow);
  assign minOk = (minAlm[7:6] == 2'b11) || (minAlm == minNow);
  assign hrOk  = (hrAlm[7:6]  == 2'b11) || (hrAlm  == hrNow);

  // R3, R7: a matching strobe sets the flag even against a clear
  p_set_on_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    (updDone && secOk && minOk && hrOk) |=> almFlag);

  // R4: a mismatching strobe cannot raise a low flag
  p_no_set_on_miss_r4: assert property (@(posedge clk) disable iff (!rstN)
    (updDone && !(secOk && minOk && hrOk) && !almFlag) |=> !almFlag);

  // R5: without a strobe a low flag stays low
  p_no_set_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!updDone && !almFlag) |=> !almFlag);

  // R6: sticky while no clear
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (almFlag && !flagClr) |=> almFlag);

  // R6: clear without a matching strobe drops the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !updDone) |=> !almFlag);

  // R8: request gated by enable
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !almIntEn |-> !irqReq);
  p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (almFlag && almIntEn) |-> irqReq);

  // R9: outputs low in reset
  always_comb begin
    if (!rstN) begin
      p_reset_low_r9: assert (!almFlag && !irqReq);
    end
  end
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .updDone  (updDone),
  .secNow   (secNow),
  .minNow   (minNow),
  .hrNow    (hrNow),
  .secAlm   (secAlm),
  .minAlm   (minAlm),
  .hrAlm    (hrAlm),
  .almIntEn (almIntEn),
  .flagClr  (flagClr),
  .almFlag  (almFlag),
  .irqReq   (irqReq)
);

// File: tb/rtc_alarm_match_tb.sv
`timescale 1ns/1ps
module rtc_alarm_match_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       updDone = 1'b0;
  logic [7:0] secNow = '0, minNow = '0, hrNow = '0;
  logic [7:0] secAlm = '0, minAlm = '0, hrAlm = '0;
  logic       almIntEn = 1'b0;
  logic       flagClr = 1'b0;
  logic       almFlag, irqReq;

  int    nRun = 0;
  int    nFail = 0;
  bit    refFlag = 1'b0;
  string curReq = "R9";

  always #10 clk = ~clk;

  rtc_alarm_match u_dut (
    .clk(clk), .rstN(rstN), .updDone(updDone),
    .secNow(secNow), .minNow(minNow), .hrNow(hrNow),
    .secAlm(secAlm), .minAlm(minAlm), .hrAlm(hrAlm),
    .almIntEn(almIntEn), .flagClr(flagClr),
    .almFlag(almFlag), .irqReq(irqReq)
  );

  function automatic bit fieldOk(input logic [7:0] alm, input logic [7:0] tm);
    return (alm >= 8'hC0) || (alm == tm);
  endfunction

  // behavioural reference: updated at each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) refFlag = 1'b0;
    else if (updDone && fieldOk(secAlm, secNow) && fieldOk(minAlm, minNow)
             && fieldOk(hrAlm, hrNow)) refFlag = 1'b1;
    else if (flagClr) refFlag = 1'b0;
  end

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // compare against model; called shortly after inputs change
  task automatic cmpModel();
    chk(curReq, almFlag, refFlag, "almFlag vs model");
    chk(curReq, irqReq, refFlag & almIntEn, "irqReq vs model");
  endtask

  task automatic setTime(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    secNow = s; minNow = m; hrNow = h;
  endtask

  task automatic setAlm(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    secAlm = s; minAlm = m; hrAlm = h;
  endtask

  // one clock: inputs applied at negedge, compared, then edge passes
  task automatic cyc(input logic upd, input logic clr);
    @(negedge clk);
    updDone = upd; flagClr = clr;
    #1 cmpModel();
    @(posedge clk);
  endtask

  task automatic expectNow(input string req, input logic f, input logic irq);
    @(negedge clk);
    updDone = 1'b0; flagClr = 1'b0;
    #1;
    chk(req, almFlag, f, "almFlag direct");
    chk(req, irqReq, irq, "irqReq direct");
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    // R9: reset with enable high and a matching strobe present
    almIntEn = 1'b1;
    updDone = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", almFlag, 1'b0, "flag in reset");
    chk("R9", irqReq, 1'b0, "irq in reset");
    @(negedge clk);
    updDone = 1'b0;
    rstN = 1'b1;

    // R5: matching bytes but no strobe
    curReq = "R5";
    setTime(8'h30, 8'h15, 8'h07);
    setAlm(8'h30, 8'h15, 8'h07);
    repeat (4) cyc(1'b0, 1'b0);
    expectNow("R5", 1'b0, 1'b0);

    // R3: strobe with full match
    curReq = "R3";
    cyc(1'b1, 1'b0);
    expectNow("R3", 1'b1, 1'b1);

    // R6: sticky through mismatched strobes, then clear
    curReq = "R6";
    setTime(8'h31, 8'h15, 8'h07);
    repeat (3) cyc(1'b1, 1'b0);
    expectNow("R6", 1'b1, 1'b1);
    cyc(1'b0, 1'b1);
    expectNow("R6", 1'b0, 1'b0);

    // R4: single field off, each in turn
    curReq = "R4";
    setTime(8'h31, 8'h15, 8'h07); cyc(1'b1, 1'b0);
    setTime(8'h30, 8'h16, 8'h07); cyc(1'b1, 1'b0);
    setTime(8'h30, 8'h15, 8'h08); cyc(1'b1, 1'b0);
    expectNow("R4", 1'b0, 1'b0);

    // R1: hour bytes differing only in bit 7 (12h PM marker)
    curReq = "R1";
    setTime(8'h30, 8'h15, 8'h87);
    cyc(1'b1, 1'b0);
    expectNow("R1", 1'b0, 1'b0);
    // R1: swapped fields must not match across pairs
    setTime(8'h15, 8'h30, 8'h07);
    cyc(1'b1, 1'b0);
    expectNow("R1", 1'b0, 1'b0);

    // R2: BFh is not a wildcard
    curReq = "R2";
    setAlm(8'hBF, 8'h15, 8'h07);
    setTime(8'h3F, 8'h15, 8'h07);
    cyc(1'b1, 1'b0);
    expectNow("R2", 1'b0, 1'b0);
    // R2: C0h and FFh wildcards
    setAlm(8'hC0, 8'hFF, 8'h07);
    setTime(8'h59, 8'h42, 8'h07);
    cyc(1'b1, 1'b0);
    expectNow("R2", 1'b1, 1'b1);
    cyc(1'b0, 1'b1);
    setAlm(8'hE5, 8'hC7, 8'hD0);
    setTime(8'h00, 8'h00, 8'h00);
    cyc(1'b1, 1'b0);
    expectNow("R2", 1'b1, 1'b1);

    // R7: clear coincident with matching strobe
    curReq = "R7";
    cyc(1'b1, 1'b1);
    expectNow("R7", 1'b1, 1'b1);
    // clear with mismatching strobe clears
    setAlm(8'h01, 8'hC0, 8'hC0);
    setTime(8'h02, 8'h00, 8'h00);
    cyc(1'b1, 1'b1);
    expectNow("R7", 1'b0, 1'b0);

    // R8: enable gating on a held flag
    curReq = "R8";
    setTime(8'h01, 8'h00, 8'h00);
    almIntEn = 1'b0;
    cyc(1'b1, 1'b0);
    expectNow("R8", 1'b1, 1'b0);
    @(negedge clk);
    almIntEn = 1'b1;
    #1;
    chk("R8", irqReq, 1'b1, "irq same cycle as enable");
    @(negedge clk);
    almIntEn = 1'b0;
    #1;
    chk("R8", irqReq, 1'b0, "irq drops with enable");
    cyc(1'b0, 1'b1);

    // random collisions of strobes, clears and matches
    curReq = "R3/R6/R7";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      secNow = 8'($urandom_range(0, 2));
      minNow = 8'($urandom_range(0, 1));
      hrNow  = 8'($urandom_range(0, 1));
      secAlm = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(8'hC0, 8'hFF)) : 8'($urandom_range(0, 2));
      minAlm = ($urandom_range(0, 3) == 0) ? 8'hC3 : 8'($urandom_range(0, 1));
      hrAlm  = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 1));
      updDone  = ($urandom_range(0, 2) == 0);
      flagClr  = ($urandom_range(0, 3) == 0);
      almIntEn = ($urandom_range(0, 1) == 0);
      #1 cmpModel();
      @(posedge clk);
    end
    expectNow("R6", refFlag, refFlag & almIntEn);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule